// File: doc/BRIEF.md
# Interrupt Source Arbiter and Vector Selector

This block sits beside the instruction sequencer of an 8/16-bit processor core. It watches four active-low hardware interrupt lines (reset, abort, non-maskable and maskable request) and the two software-interrupt requests that the instruction decoder raises (break and coprocessor call). At each instruction boundary it picks one source to service and reports a 3-bit cause code and the 24-bit address of the vector word. Abort is the only source that is taken without waiting for a boundary.

The vector table depends on the processor mode. In emulation mode the maskable request and break share one vector. In native mode they have separate vectors. Reset has no native-mode entry, so a reset always reports the emulation-mode reset vector. The interrupt-disable flag is sampled so that it can mask the maskable request. Stack pushes, program-counter loading and bus timing belong to the sequencer that consumes these outputs.

Top module: `int_arbiter`

## Requirements
- R1: All four hardware lines are active low. Reset, abort and the maskable request act on their level. The non-maskable line acts on a high-to-low transition between two clock samples, which is latched as pending until that source is serviced; a line held low produces exactly one service.
- R2: With `iflag_i` high, a low `irq_n_i` is never serviced. The flag has no effect on any other source.
- R3: When several sources are eligible in the same cycle, the winner is reset, then abort, then NMI, then IRQ, then break, then coprocessor call.
- R4: Reset, NMI, IRQ, break and coprocessor call become eligible only in a cycle with `boundary_i` high. A low `abort_n_i` is eligible in every cycle.
- R5: The selection is made from the inputs of one cycle and appears on `service_valid_o`, `cause_o` and `vector_o` after the next rising clock edge, lasting one cycle. The cause codes are 0 reset, 1 abort, 2 NMI, 3 IRQ, 4 break, 5 coprocessor call.
- R6: With `emu_i` high the vectors are abort 0x00FFF8, coprocessor 0x00FFF4, NMI 0x00FFFA, and IRQ and break both 0x00FFFE.
- R7: With `emu_i` low the vectors are abort 0x00FFE8, coprocessor 0x00FFE4, break 0x00FFE6, NMI 0x00FFEA and IRQ 0x00FFEE.
- R8: A reset service always reports vector 0x00FFFC, whatever the value of `emu_i`.
- R9: A one-cycle `brk_req_i` or `cop_req_i` pulse is held pending until that source is serviced, so it is not lost when a hardware source wins; break is taken before coprocessor call. A reset service discards both pending software requests.
- R10: `nmi_ack_o` is high in exactly the cycles in which an NMI service is reported.
- R11: After `rst_n` and in any cycle after a selection cycle with no eligible source, `service_valid_o` and `nmi_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| res_n_i | input | 1 | Processor reset line, active low, level |
| abort_n_i | input | 1 | Abort line, active low, level, no boundary needed |
| nmi_n_i | input | 1 | Non-maskable line, active low, falling edge |
| irq_n_i | input | 1 | Maskable request line, active low, level |
| brk_req_i | input | 1 | Break request pulse from the decoder |
| cop_req_i | input | 1 | Coprocessor-call request pulse from the decoder |
| iflag_i | input | 1 | Interrupt-disable flag |
| emu_i | input | 1 | 1 = emulation mode, 0 = native mode |
| boundary_i | input | 1 | Instruction-boundary strobe |
| service_valid_o | output | 1 | A service is reported this cycle |
| cause_o | output | 3 | Cause code of the reported service |
| vector_o | output | 24 | Vector address of the reported service |
| nmi_ack_o | output | 1 | NMI pending cleared by this service |

## Verification
Every result of this block is due exactly one rising edge after the cycle whose inputs produced it: the bench drives a cycle's inputs at the falling edge, lets one rising edge pass and compares the outputs at the following falling edge. The pending NMI, break and coprocessor state is tracked in a bench model that updates at that same rising edge, so a request that loses arbitration is expected at a later boundary rather than at once. Abort is checked in cycles without a boundary to show that it needs no strobe, and the masked IRQ and held NMI cases are observed on the outputs over several later cycles.

// File: rtl/int_arb_pkg.sv
package int_arb_pkg;

   localparam int NUM_SRC = 6;
   localparam int CAUSE_W = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CS_RESET = 3'd0,
      CS_ABORT = 3'd1,
      CS_NMI   = 3'd2,
      CS_IRQ   = 3'd3,
      CS_BRK   = 3'd4,
      CS_COP   = 3'd5
   } cause_e;

   // Low nibble of the vector word within its 16-byte page.
   function automatic logic [3:0] vec_nibble(cause_e c, logic emu);
      case (c)
         CS_RESET: vec_nibble = 4'hC;
         CS_ABORT: vec_nibble = 4'h8;
         CS_NMI:   vec_nibble = 4'hA;
         CS_IRQ:   vec_nibble = 4'hE;
         CS_BRK:   vec_nibble = emu ? 4'hE : 4'h6;
         default:  vec_nibble = 4'h4;
      endcase
   endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n_i,
   input  logic take_i,
   output logic pend_o
);

   logic nmi_s;
   logic nmi_prev_q;
   logic pend_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_n_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], nmi_n_i};
         end
         assign nmi_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   logic fall;
   assign fall   = nmi_prev_q & ~nmi_s;
   assign pend_o = pend_q | fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         pend_q     <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_s;
         pend_q     <= pend_o & ~take_i;
      end
   end

endmodule

// File: rtl/int_priority_pick.sv
module int_priority_pick
   import int_arb_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0]       elig_i,
   output logic               any_o,
   output logic [CAUSE_W-1:0] sel_o
);

   always_comb begin
      any_o = 1'b0;
      sel_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (elig_i[k]) begin
            any_o = 1'b1;
            sel_o = CAUSE_W'(k);
         end
      end
   end

endmodule

// File: rtl/vec_table.sv
module vec_table
   import int_arb_pkg::*;
#(
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] EMU_PAGE = 24'h00FFF0,
   parameter logic [ADDR_W-1:0] NAT_PAGE = 24'h00FFE0
) (
   input  cause_e            cause_i,
   input  logic              emu_i,
   output logic [ADDR_W-1:0] vec_o
);

   logic use_emu;
   assign use_emu = emu_i | (cause_i == CS_RESET);

   always_comb begin
      vec_o        = use_emu ? EMU_PAGE : NAT_PAGE;
      vec_o[3:0]   = vec_nibble(cause_i, use_emu);
   end

endmodule

// File: rtl/int_arbiter.sv
module int_arbiter
   import int_arb_pkg::*;
#(
   parameter int                ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] EMU_PAGE    = 24'h00FFF0,
   parameter logic [ADDR_W-1:0] NAT_PAGE    = 24'h00FFE0,
   parameter int                SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               res_n_i,
   input  logic               abort_n_i,
   input  logic               nmi_n_i,
   input  logic               irq_n_i,
   input  logic               brk_req_i,
   input  logic               cop_req_i,
   input  logic               iflag_i,
   input  logic               emu_i,
   input  logic               boundary_i,
   output logic               service_valid_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [ADDR_W-1:0]  vector_o,
   output logic               nmi_ack_o
);

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("int_arbiter: ADDR_W must be at least 16");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("int_arbiter: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic               nmi_pend;
   logic               brk_pend_q;
   logic               cop_pend_q;
   logic               brk_eff;
   logic               cop_eff;
   logic [NUM_SRC-1:0] elig;
   logic               any;
   logic [CAUSE_W-1:0] sel;
   cause_e             sel_c;
   logic [ADDR_W-1:0]  vec;
   logic               take_nmi;
   logic               take_rst;

   assign brk_eff = brk_pend_q | brk_req_i;
   assign cop_eff = cop_pend_q | cop_req_i;

   always_comb begin
      elig           = '0;
      elig[CS_RESET] = boundary_i & ~res_n_i;
      elig[CS_ABORT] = ~abort_n_i;
      elig[CS_NMI]   = boundary_i & nmi_pend;
      elig[CS_IRQ]   = boundary_i & ~irq_n_i & ~iflag_i;
      elig[CS_BRK]   = boundary_i & brk_eff;
      elig[CS_COP]   = boundary_i & cop_eff;
   end

   int_priority_pick #(.N(NUM_SRC)) u_pick (
      .elig_i (elig),
      .any_o  (any),
      .sel_o  (sel)
   );

   assign sel_c    = cause_e'(sel);
   assign take_nmi = any & (sel_c == CS_NMI);
   assign take_rst = any & (sel_c == CS_RESET);

   nmi_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_n_i (nmi_n_i),
      .take_i  (take_nmi),
      .pend_o  (nmi_pend)
   );

   vec_table #(
      .ADDR_W   (ADDR_W),
      .EMU_PAGE (EMU_PAGE),
      .NAT_PAGE (NAT_PAGE)
   ) u_vec (
      .cause_i (sel_c),
      .emu_i   (emu_i),
      .vec_o   (vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_pend_q      <= 1'b0;
         cop_pend_q      <= 1'b0;
         service_valid_o <= 1'b0;
         cause_o         <= '0;
         vector_o        <= '0;
         nmi_ack_o       <= 1'b0;
      end else begin
         brk_pend_q      <= brk_eff & ~take_rst & ~(any & (sel_c == CS_BRK));
         cop_pend_q      <= cop_eff & ~take_rst & ~(any & (sel_c == CS_COP));
         service_valid_o <= any;
         cause_o         <= any ? sel : '0;
         vector_o        <= any ? vec : '0;
         nmi_ack_o       <= take_nmi;
      end
   end

endmodule

// File: rtl/int_arbiter_chk.sv
module int_arbiter_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort_n_i,
   input logic              iflag_i,
   input logic              boundary_i,
   input logic              service_valid_o,
   input logic [2:0]        cause_o,
   input logic [ADDR_W-1:0] vector_o,
   input logic              nmi_ack_o
);

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   p_cause_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      service_valid_o |-> (cause_o <= 3'd5));

   p_ack_with_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_ack_o |-> (service_valid_o && cause_o == 3'd2));

   p_nmi_has_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (service_valid_o && cause_o == 3'd2) |-> nmi_ack_o);

   p_irq_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && service_valid_o && cause_o == 3'd3) |-> !$past(iflag_i));

   p_boundary_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && service_valid_o && cause_o != 3'd1) |-> $past(boundary_i));

   p_abort_prompt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !$past(abort_n_i)) |->
         (service_valid_o && (cause_o == 3'd1 || cause_o == 3'd0)));

   p_reset_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (service_valid_o && cause_o == 3'd0) |-> (vector_o == ADDR_W'(24'h00FFFC)));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !service_valid_o |-> !nmi_ack_o);

endmodule

bind int_arbiter int_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .abort_n_i       (abort_n_i),
   .iflag_i         (iflag_i),
   .boundary_i      (boundary_i),
   .service_valid_o (service_valid_o),
   .cause_o         (cause_o),
   .vector_o        (vector_o),
   .nmi_ack_o       (nmi_ack_o)
);

// File: tb/int_arbiter_tb.sv
module int_arbiter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_n = 1'b1, abort_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1;
   logic        brk = 1'b0, cop = 1'b0, ifl = 1'b0, emu = 1'b1, bnd = 1'b0;
   logic        valid, ack;
   logic [2:0]  cause;
   logic [23:0] vec;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   logic m_prev_nmi = 1'b1, m_nmi_pend = 1'b0, m_brk_pend = 1'b0, m_cop_pend = 1'b0;

   always #5 clk = ~clk;

   int_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .res_n_i(res_n), .abort_n_i(abort_n),
      .nmi_n_i(nmi_n), .irq_n_i(irq_n), .brk_req_i(brk), .cop_req_i(cop),
      .iflag_i(ifl), .emu_i(emu), .boundary_i(bnd),
      .service_valid_o(valid), .cause_o(cause), .vector_o(vec), .nmi_ack_o(ack)
   );

   function automatic logic [23:0] exp_vec(int c, logic e);
      logic en;
      en = e | (c == 0);
      case (c)
         0: return 24'h00FFFC;
         1: return en ? 24'h00FFF8 : 24'h00FFE8;
         2: return en ? 24'h00FFFA : 24'h00FFEA;
         3: return en ? 24'h00FFFE : 24'h00FFEE;
         4: return en ? 24'h00FFFE : 24'h00FFE6;
         default: return en ? 24'h00FFF4 : 24'h00FFE4;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // one cycle: inputs held from this falling edge, result compared at the next one
   task automatic step(input string tag, input logic rs, ab, nm, iq, br, cp, fl, em, bd);
      logic fall, ne, be, ce;
      logic [5:0] el;
      int sel;
      res_n = rs; abort_n = ab; nmi_n = nm; irq_n = iq; brk = br; cop = cp;
      ifl = fl; emu = em; bnd = bd;
      fall = m_prev_nmi & ~nm;
      ne = m_nmi_pend | fall;
      be = m_brk_pend | br;
      ce = m_cop_pend | cp;
      el = {bd & ce, bd & be, bd & ~iq & ~fl, bd & ne, ~ab, bd & ~rs};
      sel = -1;
      for (int k = 5; k >= 0; k--) if (el[k]) sel = k;
      @(posedge clk);
      m_prev_nmi = nm;
      m_nmi_pend = (sel == 2) ? 1'b0 : ne;
      m_brk_pend = (sel == 0 || sel == 4) ? 1'b0 : be;
      m_cop_pend = (sel == 0 || sel == 5) ? 1'b0 : ce;
      @(negedge clk);
      chk(valid == (sel >= 0), tag, "valid", int'(valid), int'(sel >= 0));
      chk(ack == (sel == 2), tag, "nmi_ack", int'(ack), int'(sel == 2));
      if (sel >= 0) begin
         chk(cause == 3'(sel), tag, "cause", int'(cause), sel);
         chk(vec == exp_vec(sel, em), tag, "vector", int'(vec), int'(exp_vec(sel, em)));
      end
   endtask

   task automatic idle(input string tag, input logic bd);
      step(tag, 1, 1, 1, 1, 0, 0, 0, emu, bd);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(valid == 1'b0 && ack == 1'b0, "R11", "reset state", int'(valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R11", 1);

      // R6 emulation vectors, R7 native vectors
      for (int m = 1; m >= 0; m--) begin
         step(m ? "R6" : "R7", 1, 0, 1, 1, 0, 0, 0, logic'(m), 1);
         step(m ? "R6" : "R7", 1, 1, 0, 1, 0, 0, 0, logic'(m), 1);
         step(m ? "R6" : "R7", 1, 1, 1, 0, 0, 0, 0, logic'(m), 1);
         step(m ? "R6" : "R7", 1, 1, 1, 1, 1, 0, 0, logic'(m), 1);
         step(m ? "R6" : "R7", 1, 1, 1, 1, 0, 1, 0, logic'(m), 1);
      end
      // R8 reset in native mode
      step("R8", 0, 1, 1, 1, 0, 0, 0, 0, 1);
      // R1 held NMI: one service only
      step("R1", 1, 1, 1, 1, 0, 0, 0, 1, 1);
      step("R1", 1, 1, 0, 1, 0, 0, 0, 1, 1);
      step("R1", 1, 1, 0, 1, 0, 0, 0, 1, 1);
      step("R1", 1, 1, 0, 1, 0, 0, 0, 1, 1);
      // R1 short pulse between boundaries is kept, R10 ack on service
      step("R1", 1, 1, 1, 1, 0, 0, 0, 1, 0);
      step("R1", 1, 1, 0, 1, 0, 0, 0, 1, 0);
      step("R1", 1, 1, 1, 1, 0, 0, 0, 1, 0);
      step("R10", 1, 1, 1, 1, 0, 0, 0, 1, 1);
      // R2 IRQ masked, NMI not masked
      step("R2", 1, 1, 1, 0, 0, 0, 1, 1, 1);
      step("R2", 1, 1, 0, 0, 0, 0, 1, 1, 1);
      step("R2", 1, 1, 1, 1, 1, 0, 1, 0, 1);
      // R4 abort without boundary, others wait
      step("R4", 1, 0, 1, 0, 1, 0, 0, 0, 0);
      step("R4", 1, 1, 1, 1, 0, 0, 0, 0, 0);
      step("R9", 1, 1, 1, 1, 0, 0, 0, 0, 1);
      // R9 BRK with IRQ: IRQ first, BRK next, then COP after BRK
      step("R9", 1, 1, 1, 0, 1, 1, 0, 1, 1);
      step("R9", 1, 1, 1, 1, 0, 0, 0, 1, 1);
      step("R9", 1, 1, 1, 1, 0, 0, 0, 1, 1);
      idle("R11", 1);
      // R9 reset discards pending software requests
      step("R9", 1, 1, 1, 1, 1, 1, 0, 1, 0);
      step("R9", 0, 1, 1, 1, 0, 0, 0, 1, 1);
      idle("R9", 1);
      // R3 everything at once
      step("R3", 0, 0, 1, 0, 1, 1, 0, 1, 1);
      step("R3", 1, 1, 0, 0, 1, 1, 0, 0, 1);
      idle("R3", 1);
      idle("R3", 1);
      idle("R3", 1);
      // R5 random mix checked against the model
      void'($urandom(32'd2024));
      for (int i = 0; i < 3000; i++) begin
         logic [9:0] r;
         r = 10'($urandom);
         step("R5", ($urandom % 16) != 0, ($urandom % 12) != 0, r[0], ($urandom % 3) != 0,
              ($urandom % 8) == 0, ($urandom % 9) == 0, r[1], r[2], r[3] | r[4]);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule